// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block steps a clock generator into and out of its low-power state. A low-going request, which may arrive with no relation to the block clock, first passes a two-stage synchronizer. The sequencer then gates every clock output low on a falling clock edge. It waits for the slow outputs to confirm that they have settled low, turns the VCO off, and only after that stops the crystal oscillator. When the request is withdrawn it restarts the oscillator and then the VCO. The outputs stay gated until a stabilization counter expires. The terminal count of that counter is a parameter, sized so that power-up stays under 4 ms.

On leaving power-on reset the block captures four strap inputs into a latch and raises an enable that turns those shared pins into outputs. Power-on reset itself runs the power-up half of the sequence, so the outputs open only after one full stabilization interval. If the request is released part way through power-down, the current step completes and power-up then starts from that point. No partial state is ever left behind.

Top module: `pd_sequencer`

## Requirements
- R1: While porN is low, gateAll=1, vcoEn=0, oscEn=1 and strapOutEn=0.
- R2: At the first rising edge after porN goes high, strapVal takes the value of strapIn and strapOutEn goes to 1. After that, changes on strapIn leave strapVal unchanged.
- R3: pdReqN passes two synchronizer flops. If it goes low just after rising edge 0, gateAll is still 0 after edges 1 and 2, and becomes 1 at the falling edge that follows edge 3.
- R4: While gated for power-down, vcoEn stays 1 until outLowAck is seen high.
- R5: At the first rising edge that sees outLowAck high during power-down, vcoEn goes to 0. oscEn goes to 0 one edge later, so the oscillator is never off while the VCO is on.
- R6: Power-up: the third rising edge after pdReqN goes high sets oscEn=1 with vcoEn still 0. The next edge sets vcoEn=1.
- R7: After vcoEn rises, gateAll stays 1 for STAB_CYCLES more rising edges and drops at the falling edge after the (STAB_CYCLES+1)-th. After reset release it drops after the (STAB_CYCLES+2)-th.
- R8: If pdReqN returns high while the block is still waiting for outLowAck, vcoEn and oscEn stay 1 throughout. gateAll drops at the falling edge after the (STAB_CYCLES+3)-th rising edge following the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock for the sequencer |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| pdReqN | input | 1 | Power-down request, active low, asynchronous |
| outLowAck | input | 1 | Slow outputs confirm they are held low |
| strapIn | input | 4 | Strap levels present during power-on reset |
| gateAll | output | 1 | 1 = all clock outputs forced low |
| vcoEn | output | 1 | VCO enable |
| oscEn | output | 1 | Crystal oscillator enable |
| strapOutEn | output | 1 | 1 = strap pins switched to output mode |
| strapVal | output | 4 | Latched strap values |

## Verification
Four strap patterns are each applied through a full power-on reset: all zeros, all ones and two alternating patterns. Each shows whether every bit is captured independently and whether a later flip of strapIn leaks through. A full power-down with a delayed acknowledge separates waiting for outLowAck from a fixed delay, and the cycle-by-cycle view of vcoEn and oscEn tells the correct order from a swapped one. A release during the acknowledge wait, compared against a release from the fully-down state, shows whether the sequence resumes at the right stage. Exact edge counts to the opening of gateAll catch off-by-one errors in the synchronizer and in the stabilization counter.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_GATE, ST_VCO_OFF, ST_DOWN, ST_OSC_ON, ST_VCO_ON, ST_STAB
  } seqState_t;

  typedef struct packed {
    logic gateReq;
    logic cntClear;
    logic cntRun;
  } seqStrobe_t;
endpackage

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       reqActive,
  input  logic       outLowAck,
  input  logic       cntDone,
  output seqStrobe_t strobe,
  output logic       vcoEn,
  output logic       oscEn
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_OSC_ON;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_RUN:     if (reqActive) nextState = ST_GATE;
      ST_GATE: begin
        if (!reqActive)     nextState = ST_STAB;
        else if (outLowAck) nextState = ST_VCO_OFF;
      end
      ST_VCO_OFF: nextState = reqActive ? ST_DOWN : ST_VCO_ON;
      ST_DOWN:    if (!reqActive) nextState = ST_OSC_ON;
      ST_OSC_ON:  nextState = ST_VCO_ON;
      ST_VCO_ON:  nextState = ST_STAB;
      ST_STAB:    if (cntDone) nextState = ST_RUN;
      default:    nextState = ST_OSC_ON;
    endcase
  end

  always_comb begin
    strobe.gateReq  = (state != ST_RUN);
    strobe.cntRun   = (state == ST_STAB);
    strobe.cntClear = (nextState == ST_STAB) && (state != ST_STAB);
    vcoEn = (state == ST_RUN) || (state == ST_GATE) ||
            (state == ST_VCO_ON) || (state == ST_STAB);
    oscEn = (state != ST_DOWN);
  end
endmodule

// File: rtl/pdseq_dp.sv
module pdseq_dp
  import pdseq_pkg::*;
#(
  parameter int STAB_CYCLES = 57000,
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W     = 4
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               pdReqN,
  input  logic [STRAP_W-1:0] strapIn,
  input  seqStrobe_t         strobe,
  output logic               reqActive,
  output logic               cntDone,
  output logic               gateAll,
  output logic               strapOutEn,
  output logic [STRAP_W-1:0] strapVal
);
  localparam int CW = $clog2(STAB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [CW-1:0]          stabCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pdReqN};
  end
  assign reqActive = ~syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)               stabCnt <= '0;
    else if (strobe.cntClear) stabCnt <= '0;
    else if (strobe.cntRun)   stabCnt <= stabCnt + 1'b1;
  end
  assign cntDone = (stabCnt == CW'(STAB_CYCLES - 1));

  always_ff @(negedge clk or negedge porN) begin
    if (!porN) gateAll <= 1'b1;
    else       gateAll <= strobe.gateReq;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      strapOutEn <= 1'b0;
      strapVal   <= '0;
    end else if (!strapOutEn) begin
      strapOutEn <= 1'b1;
      strapVal   <= strapIn;
    end
  end
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer #(
  parameter int STAB_CYCLES = 57000
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       pdReqN,
  input  logic       outLowAck,
  input  logic [3:0] strapIn,
  output logic       gateAll,
  output logic       vcoEn,
  output logic       oscEn,
  output logic       strapOutEn,
  output logic [3:0] strapVal
);
  pdseq_pkg::seqStrobe_t strobe;
  logic reqActive, cntDone;

  pdseq_ctrl u_ctrl (
    .clk(clk), .porN(porN), .reqActive(reqActive), .outLowAck(outLowAck),
    .cntDone(cntDone), .strobe(strobe), .vcoEn(vcoEn), .oscEn(oscEn)
  );

  pdseq_dp #(.STAB_CYCLES(STAB_CYCLES), .SYNC_STAGES(2), .STRAP_W(4)) u_dp (
    .clk(clk), .porN(porN), .pdReqN(pdReqN), .strapIn(strapIn),
    .strobe(strobe), .reqActive(reqActive), .cntDone(cntDone),
    .gateAll(gateAll), .strapOutEn(strapOutEn), .strapVal(strapVal)
  );
endmodule

// File: rtl/pdseq_checker.sv
module pdseq_checker (
  input logic       clk,
  input logic       porN,
  input logic       gateAll,
  input logic       vcoEn,
  input logic       oscEn,
  input logic       strapOutEn,
  input logic [3:0] strapVal
);
  assert_vco_off_needs_gate_R4: assert property (@(posedge clk) disable iff (!porN)
    $fell(vcoEn) |-> gateAll);
  assert_osc_off_implies_vco_off_R5: assert property (@(posedge clk) disable iff (!porN)
    !oscEn |-> !vcoEn);
  assert_osc_fall_after_vco_R5: assert property (@(posedge clk) disable iff (!porN)
    $fell(oscEn) |-> $past(!vcoEn));
  assert_vco_on_needs_osc_R6: assert property (@(posedge clk) disable iff (!porN)
    $rose(vcoEn) |-> oscEn);
  assert_open_only_when_running_R7: assert property (@(posedge clk) disable iff (!porN)
    $fell(gateAll) |-> (vcoEn && oscEn));
  assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (!porN)
    strapOutEn |=> $stable(strapVal));
endmodule

bind pd_sequencer pdseq_checker u_chk (
  .clk(clk), .porN(porN), .gateAll(gateAll), .vcoEn(vcoEn), .oscEn(oscEn),
  .strapOutEn(strapOutEn), .strapVal(strapVal)
);

// File: tb/sim_pd_sequencer.sv
module sim_pd_sequencer;
  localparam int CLK_P = 10;
  localparam int STAB  = 16;
  localparam logic [3:0] STRAPS [4] = '{4'b0000, 4'b1111, 4'b1010, 4'b0101};

  logic clk = 1'b0, porN = 1'b0, pdReqN = 1'b1, outLowAck = 1'b0;
  logic [3:0] strapIn = 4'b0000;
  logic gateAll, vcoEn, oscEn, strapOutEn;
  logic [3:0] strapVal;
  int nRun = 0, nFail = 0;

  pd_sequencer #(.STAB_CYCLES(STAB)) u0 (
    .clk(clk), .porN(porN), .pdReqN(pdReqN), .outLowAck(outLowAck),
    .strapIn(strapIn), .gateAll(gateAll), .vcoEn(vcoEn), .oscEn(oscEn),
    .strapOutEn(strapOutEn), .strapVal(strapVal)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #(CLK_P/2 + 1);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stepsToOpen(output int n, input bit needUp);
    n = 0;
    while (gateAll && n < 500) begin
      step();
      n++;
      if (needUp && gateAll) chk(vcoEn && oscEn, "R8 up", {vcoEn, oscEn}, 3);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    nFail++;
    nRun++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int n;
    #(CLK_P/2 + 1);
    foreach (STRAPS[i]) begin
      porN = 1'b0;
      strapIn = STRAPS[i];
      step(); step();
      chk(gateAll && !vcoEn && oscEn && !strapOutEn, "R1 reset",
          {gateAll, vcoEn, oscEn, strapOutEn}, 4'b1010);
      porN = 1'b1;
      step();
      chk(strapOutEn && strapVal == STRAPS[i], "R2 capture", strapVal, STRAPS[i]);
      strapIn = ~STRAPS[i];
      step();
      chk(strapVal == STRAPS[i], "R2 ignore later", strapVal, STRAPS[i]);
      stepsToOpen(n, 1'b0);
      chk(n == STAB, "R7 after reset", n, STAB);
    end

    // power-down
    pdReqN = 1'b0;
    step(); step();
    chk(!gateAll, "R3 sync delay", gateAll, 0);
    step();
    chk(gateAll && vcoEn, "R3 gate", {gateAll, vcoEn}, 3);
    step(); step(); step();
    chk(vcoEn && oscEn, "R4 wait ack", {vcoEn, oscEn}, 3);
    outLowAck = 1'b1;
    step();
    chk(!vcoEn && oscEn, "R5 vco first", {vcoEn, oscEn}, 1);
    step();
    chk(!vcoEn && !oscEn, "R5 osc second", {vcoEn, oscEn}, 0);
    step();
    chk(!oscEn && gateAll, "R5 stays down", {oscEn, gateAll}, 1);

    // power-up
    outLowAck = 1'b0;
    pdReqN = 1'b1;
    step(); step();
    chk(!oscEn, "R6 sync delay", oscEn, 0);
    step();
    chk(oscEn && !vcoEn, "R6 osc first", {oscEn, vcoEn}, 2);
    step();
    chk(vcoEn && gateAll, "R6 vco second", {vcoEn, gateAll}, 3);
    stepsToOpen(n, 1'b0);
    chk(n == STAB + 1, "R7 stab count", n, STAB + 1);

    // release while waiting for ack
    pdReqN = 1'b0;
    step(); step(); step();
    chk(gateAll, "R8 gated", gateAll, 1);
    pdReqN = 1'b1;
    stepsToOpen(n, 1'b1);
    chk(n == STAB + 3, "R8 release count", n, STAB + 3);
    chk(vcoEn && oscEn, "R8 running", {vcoEn, oscEn}, 3);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule